// File: doc/BRIEF.md
# Burst Initial-Latency Wait-State Counter

This block times the first data word of a synchronous burst read. A burst starts when the active-low address-valid strobe falls. The block then counts clock cycles up to the configured initial access latency. When the count is done it raises a one-cycle enable for the first data word. It also raises a one-cycle ready indication, which comes either one cycle ahead of that enable or together with it.

The latency is set by a 3-bit code. The code is taken from bits 13 down to 11 of the configuration word and latched when a load strobe is asserted. Codes 0 to 5 select 2 to 7 total initial access cycles. The two reserved codes fall back to the 7-cycle default, which is also the value after reset. Counting is used only while the synchronous mode input is high. In asynchronous mode a strobe starts no count and both outputs stay low.

The latency and the mode are captured when the strobe falls. A later load of the code therefore applies from the next access onward. A new falling strobe during a count drops the old count and starts a fresh one.

Top module: `burst_lat_ctr`

## Requirements
- R1: After reset the latency code is 3'b101, so a synchronous access with no code load puts data_en high 7 cycles after the strobe (N = 7).
- R2: Timing is counted from the rising edge k that first samples adv_n low after it was high. data_en is high for exactly the one cycle that follows edge k+N-1, where N = code + 2 for codes 3'b000 to 3'b101.
- R3: The reserved codes 3'b110 and 3'b111 behave as N = 7.
- R4: When N = 2, rdy is high in the same single cycle as data_en.
- R5: When N > 2, rdy is high for the single cycle after edge k+N-2, which is one cycle before data_en.
- R6: If sync_mode is low at edge k, that access produces no rdy and no data_en.
- R7: A new falling strobe at a later edge during a count abandons the old count, and timing restarts from the new edge.
- R8: The code and the mode are captured at edge k. A load of lat_code_in during the count does not change the current access, and it takes effect for the next one.
- R9: A strobe held low for several cycles starts a single access. Each access gives exactly one data_en pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| adv_n | input | 1 | Address-valid strobe, active low; a falling edge starts an access |
| sync_mode | input | 1 | 1 = synchronous burst mode (counting on), 0 = asynchronous (counter bypassed) |
| lat_load | input | 1 | Loads lat_code_in into the latency register |
| lat_code_in | input | 3 | Latency field, bits 13:11 of the configuration word |
| rdy | output | 1 | One-cycle ready indication for the first word |
| data_en | output | 1 | One-cycle enable for the first data word |

## Verification
A wrong count state shows up as data_en one or more cycles early or late against the strobe. It can also show up as a missing pulse or a doubled pulse. The bench sees this within at most seven cycles of the strobe. A latched target that is corrupted, or a reserved code that is decoded wrongly, moves both rdy and data_en by the same offset. A fault in the ready offset shows up as rdy arriving in the wrong cycle relative to data_en, first seen on a 2-cycle access or a 3-cycle access. A failure to drop the old count on a restart gives a stray data_en from the abandoned access. A missing edge detection gives repeated pulses while the strobe is held low.

// File: rtl/burst_lat_pkg.sv
package burst_lat_pkg;

    localparam int LAT_W   = 3;   // width of the latency code field
    localparam int CNT_W   = 3;   // counter width, holds up to the largest latency
    localparam int MIN_LAT = 2;   // latency selected by code zero

    typedef logic [LAT_W-1:0] code_t;
    typedef logic [CNT_W-1:0] lat_t;

    typedef enum logic [LAT_W-1:0] {
        LC_2  = 3'd0,
        LC_3  = 3'd1,
        LC_4  = 3'd2,
        LC_5  = 3'd3,
        LC_6  = 3'd4,
        LC_7  = 3'd5,
        LC_R6 = 3'd6,
        LC_R7 = 3'd7
    } lat_code_e;

    localparam lat_code_e DEF_CODE = LC_7;
    localparam lat_t      MAX_LAT  = lat_t'(7);
    localparam lat_t      ONE      = lat_t'(1);
    localparam lat_t      TWO      = lat_t'(2);

    typedef struct packed {
        logic busy;
        lat_t cnt;
        lat_t tgt;
    } ctr_state_t;

    // Map a code to its total initial access cycles; the reserved codes fold to the default.
    function automatic lat_t decode_lat(lat_code_e code);
        lat_t n;
        case (code)
            LC_R6, LC_R7: n = MAX_LAT;
            default:      n = lat_t'(code) + lat_t'(MIN_LAT);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/lat_code_reg.sv
module lat_code_reg
    import burst_lat_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  code_t     code_in,
    output lat_code_e code_q
);
    always_ff @(posedge clk) begin
        if (rst)       code_q <= DEF_CODE;
        else if (load) code_q <= lat_code_e'(code_in);
    end
endmodule

// File: rtl/strobe_fall_det.sv
module strobe_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic start
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= strobe_n;
    end

    assign start = prev_q & ~strobe_n;
endmodule

// File: rtl/lat_counter.sv
module lat_counter
    import burst_lat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       sync_on,
    input  lat_t       lat,
    output ctr_state_t st_q,
    output logic       rdy_q,
    output logic       data_q
);
    ctr_state_t st_d;
    logic       rdy_d;
    logic       data_d;
    logic       rdy_hit;

    always_comb begin
        if (st_q.tgt == TWO) rdy_hit = (st_q.cnt == ONE);
        else                 rdy_hit = (st_q.cnt == st_q.tgt - TWO);
    end

    always_comb begin
        st_d   = st_q;
        rdy_d  = 1'b0;
        data_d = 1'b0;
        if (start) begin
            st_d.busy = sync_on;
            st_d.cnt  = ONE;
            st_d.tgt  = lat;
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt + ONE;
            rdy_d    = rdy_hit;
            if (st_q.cnt == st_q.tgt - ONE) begin
                st_d.busy = 1'b0;
                data_d    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '{busy: 1'b0, cnt: '0, tgt: MAX_LAT};
            rdy_q  <= 1'b0;
            data_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            rdy_q  <= rdy_d;
            data_q <= data_d;
        end
    end
endmodule

// File: rtl/burst_lat_ctr.sv
module burst_lat_ctr
    import burst_lat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_n,
    input  logic             sync_mode,
    input  logic             lat_load,
    input  logic [LAT_W-1:0] lat_code_in,
    output logic             rdy,
    output logic             data_en
);
    lat_code_e  code_q;
    logic       start;
    ctr_state_t st;
    logic       busy_w;
    lat_t       cnt_w;
    lat_t       tgt_w;

    lat_code_reg u_code (
        .clk     (clk),
        .rst     (rst),
        .load    (lat_load),
        .code_in (lat_code_in),
        .code_q  (code_q)
    );

    strobe_fall_det u_edge (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (adv_n),
        .start    (start)
    );

    lat_counter u_ctr (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .sync_on (sync_mode),
        .lat     (decode_lat(code_q)),
        .st_q    (st),
        .rdy_q   (rdy),
        .data_q  (data_en)
    );

    assign busy_w = st.busy;
    assign cnt_w  = st.cnt;
    assign tgt_w  = st.tgt;
endmodule

// File: rtl/burst_lat_chk.sv
module burst_lat_chk
    import burst_lat_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic adv_n,
    input logic sync_mode,
    input logic rdy,
    input logic data_en,
    input logic busy,
    input lat_t cnt,
    input lat_t tgt
);
    // R6
    async_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!adv_n && $past(adv_n) && !sync_mode) |=> (!rdy && !data_en));

    // R4
    rdy_with_data_chk: assert property (@(posedge clk) disable iff (rst)
        data_en |-> (rdy || $past(rdy)));

    // R5
    rdy_then_data_chk: assert property (@(posedge clk) disable iff (rst)
        (rdy && !data_en && !(!adv_n && $past(adv_n))) |=> data_en);

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        data_en |=> !data_en);

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < tgt && tgt >= TWO && tgt <= MAX_LAT));
endmodule

bind burst_lat_ctr burst_lat_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .adv_n     (adv_n),
    .sync_mode (sync_mode),
    .rdy       (rdy),
    .data_en   (data_en),
    .busy      (busy_w),
    .cnt       (cnt_w),
    .tgt       (tgt_w)
);

// File: tb/burst_lat_ctr_tb.sv
`timescale 1ns/1ps
module burst_lat_ctr_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adv_n = 1'b1;
    logic       sync_mode = 1'b0;
    logic       lat_load = 1'b0;
    logic [2:0] lat_code_in = 3'd0;
    logic       rdy;
    logic       data_en;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_lat_ctr u_dut (
        .clk         (clk),
        .rst         (rst),
        .adv_n       (adv_n),
        .sync_mode   (sync_mode),
        .lat_load    (lat_load),
        .lat_code_in (lat_code_in),
        .rdy         (rdy),
        .data_en     (data_en)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input logic act, input logic exp, input string tag, input int idx);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at index %0d: actual=%b expected=%b", tag, idx, act, exp);
        end
    endtask

    function automatic int lat_of(input int code);
        return (code <= 5) ? code + 2 : 7;
    endfunction

    task automatic load_code(input int code);
        @(negedge clk);
        lat_load    = 1'b1;
        lat_code_in = code[2:0];
        @(negedge clk);
        lat_load    = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Strobe falls at the next edge k; index i observes the outputs after edge k+i.
    // n_exp = 0 means no pulse is expected. wr_at >= 0 loads wr_code for edge k+wr_at+1.
    task automatic access(input int n_exp, input int hold, input int cycles,
                          input int wr_at, input int wr_code, input string tag);
        adv_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < cycles; i++) begin
            int  ridx;
            logic ed;
            logic er;
            ridx = (n_exp == 2) ? 1 : n_exp - 2;
            ed = (n_exp != 0) && (i == n_exp - 1);
            er = (n_exp != 0) && (i == ridx);
            check(data_en, ed, {tag, " data_en"}, i);
            check(rdy, er, (n_exp == 2) ? {tag, "/R4 rdy"} : {tag, "/R5 rdy"}, i);
            adv_n = (i + 1 < hold) ? 1'b0 : 1'b1;
            if (i == wr_at) begin
                lat_load    = 1'b1;
                lat_code_in = wr_code[2:0];
            end else begin
                lat_load = 1'b0;
            end
            @(negedge clk);
        end
        adv_n    = 1'b1;
        lat_load = 1'b0;
    endtask

    initial begin
        idle(3);
        check(rdy, 1'b0, "reset rdy", 0);
        check(data_en, 1'b0, "reset data_en", 0);
        rst = 1'b0;
        sync_mode = 1'b1;
        idle(2);

        // R1: default latency after reset
        access(7, 1, 10, -1, 0, "R1 default");
        idle(2);

        // R2, R3: sweep every code
        for (int c = 0; c < 8; c++) begin
            load_code(c);
            idle(1);
            access(lat_of(c), 1, 10, -1, 0, (c <= 5) ? "R2 code" : "R3 reserved");
            idle(2);
        end

        // R6: asynchronous mode produces nothing
        load_code(2);
        sync_mode = 1'b0;
        idle(1);
        access(0, 1, 10, -1, 0, "R6 async");
        sync_mode = 1'b1;
        idle(2);

        // R7: restart during a count (N = 5)
        load_code(3);
        idle(1);
        access(5, 1, 2, -1, 0, "R7 first");
        access(5, 1, 10, -1, 0, "R7 restart");
        idle(2);

        // R8: load during count does not affect current access, applies to next
        load_code(5);
        idle(1);
        access(7, 1, 10, 1, 0, "R8 current");
        idle(2);
        access(2, 1, 10, -1, 0, "R8 next");
        idle(2);

        // R9: held strobe gives one access (N = 3)
        load_code(1);
        idle(1);
        access(3, 5, 12, -1, 0, "R9 held");
        idle(2);

        // R1: reset restores default after other codes
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(2);
        access(7, 1, 10, -1, 0, "R1 after reset");
        idle(2);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule